// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of sixteen pins, configured through a 32-bit word-addressed register interface. Each pin has a two-bit direction/function code, a one-bit driver type (push-pull or open-drain), a two-bit pull selection and an output data bit. The output data bits can be loaded whole, changed through an atomic set/clear word, or cleared through a clear-only word.

Every pin has an external drive port. A strobe with a level models an outside source driving the pin, and a release pulse models that source letting go. From the configuration and the external drive, the block resolves the level of each pin. The result can be read back as a read-only input word and is also driven out, one wire per pin, to a system-configuration block. The block also keeps a mask of the pins that currently have no external driver. An open-drain or push-pull driver can reject an external drive, and that pin is then counted as undriven.

The reset configuration comes from a port-index parameter, so the same source serves every port of a chip. Pins whose reset pull is an up-pull read high out of reset, and all other undriven, unpulled pins read low.

Top module: `gpio_port`

## Requirements
- R1: After reset with port index 0, the direction word reads 0xABFFFFFF, the pull word reads 0x64000000 and the input word reads 0x0000A000. The type and output words read 0, and the undriven mask is 0xFFFF. Port 1 resets to direction 0xFFFFFEBF and pull 0x00000100, ports 2 to 6 to direction 0xFFFFFFFF, and port 7 to direction 0x0000000F.
- R2: The direction word (offset 0x00) holds 2 bits per pin at bits 2p+1:2p. Code 01 makes the pin an output. Codes 00, 10 and 11 all behave as input.
- R3: A write to the set/clear word (offset 0x18) sets output bit p for each 1 in bit p (15:0) and clears it for each 1 in bit p+16. A pin with both bits set ends up set. The word reads 0.
- R4: A write to the clear-only word (offset 0x28) clears output bit p for each 1 in bit p (15:0) and leaves the pins with a 0 unchanged. The word reads 0.
- R5: Output data (offset 0x14, bits 15:0) written while a pin is not an output is kept. It appears on the pin as soon as the pin's code becomes 01.
- R6: A push-pull output (type bit 0 at offset 0x04) reads its output data bit. From the edge after it is configured, its undriven-mask bit is 1, and a later external drive leaves both its level and that bit unchanged.
- R7: An open-drain output (type bit 1) with data 0 reads 0 and is marked undriven. With data 1, an external low is accepted: the pin is marked driven and reads 0. An external high is rejected: the pin is marked undriven and reads its pull value.
- R8: For an input pin, the pull word (offset 0x0C) holds 2 bits per pin, with 00 = none, 01 = up, 10 = down and 11 = none. A driven input reads the external level. An undriven input reads 1 with an up-pull and 0 otherwise.
- R9: An accepted external drive clears the pin's undriven-mask bit on the next edge. A release, or a rejected drive, sets it on the next edge, and a release takes priority over a strobe on the same pin.
- R10: The per-pin level output always equals the value of the input word (offset 0x10) and follows every change of it in the same cycle.
- R11: Writes reach the registers on the next clock edge. The input word ignores writes, and unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_strobe | input | 16 | Per pin: an outside source drives the pin this cycle |
| ext_level | input | 16 | Per pin: the level driven with the strobe |
| ext_release | input | 16 | Per pin: the outside source lets go |
| pin_level | output | 16 | Resolved pin levels toward system configuration |
| float_mask | output | 16 | Per pin: 1 when no external driver is connected |

## Verification
On every cycle, the assertions check that a push-pull output or an open-drain output holding a 0 is marked undriven on the next edge. They also check that a release always marks its pin undriven, that an accepted drive on an input marks it driven, that the set/clear and clear-only words leave set-wins and unchanged-bits results, and that a write to the input word leaves the configuration untouched. The resolved levels show the remaining behaviour: the pull fallback, the rejection of an external high on an open-drain pin, retained output data taking effect when the code changes, and the reset image. These appear only in the bench scenarios, which its behavioural model also follows on every cycle.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TYPE   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PULL   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_IN     = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SETCLR = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h28;

  localparam logic [1:0] DIR_OUT = 2'b01;
  localparam logic [1:0] PULL_UP = 2'b01;

  function automatic logic [31:0] dir_reset(input int unsigned idx);
    case (idx)
      0:       return 32'hABFF_FFFF;
      1:       return 32'hFFFF_FEBF;
      7:       return 32'h0000_000F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pull_reset(input int unsigned idx);
    case (idx)
      0:       return 32'h6400_0000;
      1:       return 32'h0000_0100;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_cfg.sv
`timescale 1ns/1ps
module gpio_port_cfg
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter int unsigned PORT_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [2*NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]    type_q,
  output logic [2*NPINS-1:0]  pull_q,
  output logic [NPINS-1:0]    out_q
);
  localparam int unsigned FW = 2 * NPINS;
  localparam logic [31:0] DIR_RST32  = dir_reset(PORT_IDX);
  localparam logic [31:0] PULL_RST32 = pull_reset(PORT_IDX);

  logic dir_en, type_en, pull_en, out_en;
  logic [NPINS-1:0] out_d;

  always_comb begin
    dir_en  = bus_wr && (bus_addr == OFS_DIR);
    type_en = bus_wr && (bus_addr == OFS_TYPE);
    pull_en = bus_wr && (bus_addr == OFS_PULL);
    out_en  = bus_wr && ((bus_addr == OFS_OUT) || (bus_addr == OFS_SETCLR) ||
                         (bus_addr == OFS_CLR));
    out_d   = out_q;
    case (bus_addr)
      OFS_OUT:    out_d = bus_wdata[NPINS-1:0];
      OFS_SETCLR: out_d = (out_q & ~bus_wdata[16 +: NPINS]) | bus_wdata[NPINS-1:0];
      OFS_CLR:    out_d = out_q & ~bus_wdata[NPINS-1:0];
      default:    out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RST32[FW-1:0];
      type_q <= '0;
      pull_q <= PULL_RST32[FW-1:0];
      out_q  <= '0;
    end else begin
      if (dir_en)  dir_q  <= bus_wdata[FW-1:0];
      if (type_en) type_q <= bus_wdata[NPINS-1:0];
      if (pull_en) pull_q <= bus_wdata[FW-1:0];
      if (out_en)  out_q  <= out_d;
    end
  end

  // R3: every set bit of a set/clear write ends up 1, even with its clear bit
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SETCLR) |=>
      ((out_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  // R4: clear-only write clears its ones and keeps every other bit
  assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLR) |=>
      (((out_q & $past(bus_wdata[NPINS-1:0])) == '0) &&
       ((out_q & ~$past(bus_wdata[NPINS-1:0])) ==
        ($past(out_q) & ~$past(bus_wdata[NPINS-1:0])))));

  // R11: a write to the input word changes no configuration
  assert_input_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IN) |=>
      ($stable(dir_q) && $stable(type_q) && $stable(pull_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_port_pin.sv
`timescale 1ns/1ps
module gpio_port_pin
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dir,
  input  logic       odrain,
  input  logic [1:0] pull,
  input  logic       out_bit,
  input  logic       drv_stb,
  input  logic       drv_lvl,
  input  logic       drv_rel,
  output logic       level,
  output logic       floating
);
  logic is_out;
  logic accept_new, accept_held;
  logic float_d, ext_q, ext_en;
  logic float_lvl;

  // Next state of the connection tracker
  always_comb begin
    is_out      = (dir == DIR_OUT);
    accept_new  = !is_out || (odrain && out_bit && !drv_lvl);
    accept_held = !is_out || (odrain && out_bit && !ext_q);
    ext_en      = drv_stb && !drv_rel && accept_new;
    float_d     = floating;
    if (drv_rel)          float_d = 1'b1;
    else if (drv_stb)     float_d = !accept_new;
    else if (!accept_held) float_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floating <= 1'b1;
      ext_q    <= 1'b0;
    end else begin
      floating <= float_d;
      if (ext_en) ext_q <= drv_lvl;
    end
  end

  // Level resolution from registered state
  always_comb begin
    float_lvl = (pull == PULL_UP);
    if (is_out) begin
      if (!odrain)                 level = out_bit;
      else if (!out_bit)           level = 1'b0;
      else if (!floating && !ext_q) level = 1'b0;
      else                          level = float_lvl;
    end else begin
      level = floating ? float_lvl : ext_q;
    end
  end

  // R6: push-pull output is undriven on the next edge
  assert_pushpull_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && !odrain) |=> floating);

  // R7: open-drain output holding 0 is undriven on the next edge
  assert_odrain_low_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && odrain && !out_bit) |=> floating);

  // R9: release always marks the pin undriven
  assert_release_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rel |=> floating);

  // R8: a drive on an input pin is accepted
  assert_input_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_out && drv_stb && !drv_rel) |=> (!floating && level == $past(drv_lvl)) or
                                         (!floating && $changed(dir)));
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter int unsigned PORT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  ext_strobe,
  input  logic [NPINS-1:0]  ext_level,
  input  logic [NPINS-1:0]  ext_release,
  output logic [NPINS-1:0]  pin_level,
  output logic [NPINS-1:0]  float_mask
);
  localparam int unsigned FW = 2 * NPINS;

  logic [FW-1:0]    dir_q, pull_q;
  logic [NPINS-1:0] type_q, out_q;

  gpio_port_cfg #(.NPINS(NPINS), .PORT_IDX(PORT_IDX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dir_q(dir_q), .type_q(type_q),
    .pull_q(pull_q), .out_q(out_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_port_pin u_pin (
      .clk(clk), .rst_n(rst_n),
      .dir(dir_q[2*p +: 2]), .odrain(type_q[p]), .pull(pull_q[2*p +: 2]),
      .out_bit(out_q[p]), .drv_stb(ext_strobe[p]), .drv_lvl(ext_level[p]),
      .drv_rel(ext_release[p]), .level(pin_level[p]), .floating(float_mask[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DIR:  bus_rdata[FW-1:0]    = dir_q;
      OFS_TYPE: bus_rdata[NPINS-1:0] = type_q;
      OFS_PULL: bus_rdata[FW-1:0]    = pull_q;
      OFS_IN:   bus_rdata[NPINS-1:0] = pin_level;
      OFS_OUT:  bus_rdata[NPINS-1:0] = out_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_wr = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [15:0] stb = '0, lvl = '0, rel = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_level, float_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .ext_strobe(stb),
    .ext_level(lvl), .ext_release(rel), .pin_level(pin_level),
    .float_mask(float_mask)
  );

  // Behavioural reference model, one entry per pin
  int m_dir[16], m_type[16], m_pull[16], m_out[16], m_float[16], m_ext[16];

  function automatic int model_level(int p);
    int fl;
    fl = (m_pull[p] == 1) ? 1 : 0;
    if (m_dir[p] == 1) begin
      if (m_type[p] == 0) return m_out[p];
      if (m_out[p] == 0) return 0;
      if (m_float[p] == 0 && m_ext[p] == 0) return 0;
      return fl;
    end
    return (m_float[p] == 0) ? m_ext[p] : fl;
  endfunction

  function automatic logic [31:0] model_read(logic [5:0] a);
    logic [31:0] v;
    v = '0;
    for (int p = 0; p < 16; p++) begin
      case (a)
        6'h00: v[2*p +: 2] = 2'(m_dir[p]);
        6'h04: v[p] = 1'(m_type[p]);
        6'h0C: v[2*p +: 2] = 2'(m_pull[p]);
        6'h10: v[p] = 1'(model_level(p));
        6'h14: v[p] = 1'(m_out[p]);
        default: ;
      endcase
    end
    return v;
  endfunction

  function automatic bit accepts(int p, int l);
    if (m_dir[p] != 1) return 1;
    return (m_type[p] == 1 && m_out[p] == 1 && l == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 16; p++) begin
        m_dir[p]   = int'((32'hABFF_FFFF >> (2*p)) & 3);
        m_pull[p]  = int'((32'h6400_0000 >> (2*p)) & 3);
        m_type[p]  = 0; m_out[p] = 0; m_float[p] = 1; m_ext[p] = 0;
      end
    end else begin
      for (int p = 0; p < 16; p++) begin
        if (rel[p]) m_float[p] = 1;
        else if (stb[p]) begin
          if (accepts(p, int'(lvl[p]))) begin m_float[p] = 0; m_ext[p] = int'(lvl[p]); end
          else m_float[p] = 1;
        end else if (!accepts(p, m_ext[p])) m_float[p] = 1;
      end
      if (b_wr) begin
        for (int p = 0; p < 16; p++) begin
          case (b_addr)
            6'h00: m_dir[p]  = int'((b_wdata >> (2*p)) & 3);
            6'h04: m_type[p] = int'(b_wdata[p]);
            6'h0C: m_pull[p] = int'((b_wdata >> (2*p)) & 3);
            6'h14: m_out[p]  = int'(b_wdata[p]);
            6'h18: begin
              if (b_wdata[p+16]) m_out[p] = 0;
              if (b_wdata[p])    m_out[p] = 1;
            end
            6'h28: if (b_wdata[p]) m_out[p] = 0;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R9, R10, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] ml, mf;
      for (int p = 0; p < 16; p++) begin
        ml[p] = 1'(model_level(p));
        mf[p] = 1'(m_float[p]);
      end
      check("R10 pin_level", {16'h0, pin_level}, {16'h0, ml});
      check("R9 float_mask", {16'h0, float_mask}, {16'h0, mf});
      check("R11 bus_rdata", bus_rdata, model_read(b_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #0.2;
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); #0.2;
    b_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    b_addr = a; #0.2;
    check(req, bus_rdata, exp);
  endtask

  task automatic rmw(input logic [5:0] a, input int p, input int w, input logic [1:0] val);
    logic [31:0] v, m;
    b_addr = a; #0.2;
    v = bus_rdata;
    m = (w == 2) ? (32'h3 << (2*p)) : (32'h1 << p);
    v = (v & ~m) | ((w == 2) ? (32'(val) << (2*p)) : (32'(val) << p));
    wr(a, v);
  endtask

  task automatic drive(input logic [15:0] m, input logic [15:0] l);
    @(negedge clk); #0.2; stb = m; lvl = l;
    @(negedge clk); #0.2; stb = '0;
  endtask

  task automatic release_pins(input logic [15:0] m);
    @(negedge clk); #0.2; rel = m;
    @(negedge clk); #0.2; rel = '0;
  endtask

  task automatic tick();
    @(negedge clk); #0.2;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    #0.2 rst_n = 1'b1;
    tick();
    // R1 reset image for port 0
    rd_chk(6'h00, 32'hABFF_FFFF, "R1 dir reset");
    rd_chk(6'h0C, 32'h6400_0000, "R1 pull reset");
    rd_chk(6'h10, 32'h0000_A000, "R1 input reset");
    rd_chk(6'h04, 32'h0, "R1 type reset");
    rd_chk(6'h14, 32'h0, "R1 out reset");
    check("R1 float mask reset", {16'h0, float_mask}, 32'h0000_FFFF);

    // R5 retained output data, R2 code 01 is output
    wr(6'h14, 32'h20);
    rd_chk(6'h10, 32'h0000_A000, "R5 data held while input");
    rmw(6'h00, 5, 2, 2'b01);
    rd_chk(6'h10, 32'h0000_A020, "R5 data drives on output");
    check("R10 pin5 level", {31'h0, pin_level[5]}, 32'h1);
    wr(6'h14, 32'h0);
    rd_chk(6'h10, 32'h0000_A000, "R6 push-pull follows data");

    // R8 driven input, R9 mask
    rmw(6'h00, 6, 2, 2'b00);
    drive(16'h0040, 16'h0040);
    rd_chk(6'h10, 32'h0000_A040, "R8 input high");
    check("R9 drive clears mask", {16'h0, float_mask}, 32'h0000_FFBF);
    drive(16'h0040, 16'h0000);
    rd_chk(6'h10, 32'h0000_A000, "R8 input low");
    release_pins(16'h0040);
    check("R9 release sets mask", {16'h0, float_mask}, 32'h0000_FFFF);
    // R2 code 10 behaves as input
    rmw(6'h00, 6, 2, 2'b10);
    drive(16'h0040, 16'h0040);
    rd_chk(6'h10, 32'h0000_A040, "R2 code 10 as input");
    release_pins(16'h0040);

    // R8 pulls
    rmw(6'h0C, 3, 2, 2'b01);
    rd_chk(6'h10, 32'h0000_A008, "R8 pull-up");
    rmw(6'h0C, 3, 2, 2'b10);
    rd_chk(6'h10, 32'h0000_A000, "R8 pull-down");

    // R6 push-pull rejects drive
    drive(16'h0080, 16'h0080);
    rd_chk(6'h10, 32'h0000_A080, "R8 analog code accepts drive");
    rmw(6'h00, 7, 2, 2'b01);
    rd_chk(6'h10, 32'h0000_A000, "R6 push-pull level");
    tick();
    check("R6 push-pull undriven", {16'h0, float_mask}, 32'h0000_FFFF);
    drive(16'h0080, 16'h0080);
    rd_chk(6'h10, 32'h0000_A000, "R6 drive ignored");
    check("R6 mask after ignored drive", {16'h0, float_mask}, 32'h0000_FFFF);

    // R7 open-drain
    wr(6'h14, 32'h100);
    rmw(6'h04, 8, 1, 2'b01);
    rmw(6'h00, 8, 2, 2'b01);
    rd_chk(6'h10, 32'h0000_A000, "R7 od floating no pull");
    drive(16'h0100, 16'h0000);
    rd_chk(6'h10, 32'h0000_A000, "R7 od external low");
    check("R7 od low connected", {16'h0, float_mask}, 32'h0000_FEFF);
    drive(16'h0100, 16'h0100);
    check("R7 od high rejected", {16'h0, float_mask}, 32'h0000_FFFF);
    rmw(6'h0C, 8, 2, 2'b01);
    rd_chk(6'h10, 32'h0000_A100, "R7 od floating pull-up");
    drive(16'h0100, 16'h0000);
    rd_chk(6'h10, 32'h0000_A000, "R7 od low over pull-up");
    wr(6'h14, 32'h0);
    tick();
    check("R7 od data 0 undriven", {16'h0, float_mask}, 32'h0000_FFFF);

    // R3 set/clear, R4 clear-only
    wr(6'h18, 32'h0000_1000);
    rd_chk(6'h14, 32'h0000_1000, "R3 set");
    wr(6'h18, 32'h1000_0000);
    rd_chk(6'h14, 32'h0, "R3 clear");
    wr(6'h18, 32'h1000_1000);
    rd_chk(6'h14, 32'h0000_1000, "R3 set wins");
    rd_chk(6'h18, 32'h0, "R3 reads zero");
    wr(6'h28, 32'h0000_1000);
    rd_chk(6'h14, 32'h0, "R4 clear");
    wr(6'h18, 32'h0000_1001);
    wr(6'h28, 32'h0000_0001);
    rd_chk(6'h14, 32'h0000_1000, "R4 zero bits unchanged");
    rd_chk(6'h28, 32'h0, "R4 reads zero");

    // R11 read-only input word and unmapped offsets
    b_addr = 6'h00; #0.2; saved = bus_rdata;
    wr(6'h10, 32'hFFFF_FFFF);
    rd_chk(6'h10, 32'h0000_A000, "R11 input word ignores write");
    wr(6'h08, 32'hFFFF_FFFF);
    rd_chk(6'h08, 32'h0, "R11 unmapped reads zero");
    rd_chk(6'h3C, 32'h0, "R11 unmapped high offset");
    rd_chk(6'h00, saved, "R11 unmapped write ignored");

    repeat (4) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule